// File: doc/BRIEF.md
# Synchronous Burst Engine for Pseudo-Static RAM

This block is the device side of a synchronous burst interface on a pseudo-static RAM. A host lowers chip enable, then presents a start address and a direction while the address-valid strobe is low. The engine captures both on that clock edge. It holds WAIT high for a configured initial latency and then moves one word per clock, either for a fixed 4-, 8- or 16-word burst or continuously until chip enable rises.

The array is organised in 128-word rows. A continuous burst can run past the end of a row. When it does, the engine raises WAIT again for a row-change latency, which stands for closing the old row and opening the next one. It then resumes at the following address. The same WAIT rules hold for reads and writes. Write data is taken only on edges that end a cycle in which WAIT is low.

Top module: `psram_burst_engine`

## Requirements
- R1: While idle, the first rising clock edge with `ce_n` low and `adv_n` low captures `addr` as the start address and `we_n` as the direction (high = read, low = write). With `adv_n` high, no burst starts. Changes to `addr` and `we_n` after the capture edge have no effect on the burst.
- R2: `wait_o` is high in the cycle after the capture edge and stays high for exactly `cfg_lat` cycles (legal values 1 to 15). The first data cycle, with `wait_o` low, follows.
- R3: `cfg_len` codes 0, 1 and 2 select fixed bursts of 4, 8 and 16 words. The address increments by one and wraps inside the aligned block of that size.
- R4: `cfg_len` code 3 selects a continuous burst. The address increments linearly and wraps from the top of memory to address 0.
- R5: In a continuous burst, after the data cycle of a word whose successor lies in another 128-word row (address bits above bit 6 differ), `wait_o` is high for `cfg_row_lat` cycles. The burst then resumes at the successor address.
- R6: A `cfg_row_lat` of 0 makes the row-change stall last `cfg_lat` cycles.
- R7: In a write burst, `wdata` is stored at the current burst address on the rising edge that ends each cycle with `wait_o` low. `wdata` presented during latency, stall or post-burst cycles is not stored.
- R8: In a read burst, `rdata` holds the word at the current burst address throughout every cycle with `wait_o` low.
- R9: After the last word of a fixed burst, `wait_o` stays low and no further word is transferred until `ce_n` goes high.
- R10: `ce_n` high at a rising edge ends any burst. `wait_o` is low from the next cycle, and no later word of that burst is stored.
- R11: Synchronous active-high `rst` returns the engine to idle with `wait_o` low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ce_n | input | 1 | Chip enable, active low |
| adv_n | input | 1 | Address-valid strobe, active low |
| we_n | input | 1 | Direction at capture: 1 read, 0 write |
| addr | input | ADDR_W | Burst start address |
| wdata | input | DATA_W | Write data |
| cfg_len | input | 2 | Burst length code: 0=4, 1=8, 2=16, 3=continuous |
| cfg_lat | input | LAT_W | Initial latency in cycles (1..15) |
| cfg_row_lat | input | LAT_W | Row-change stall in cycles; 0 means use cfg_lat |
| rdata | output | DATA_W | Read data, registered |
| wait_o | output | 1 | WAIT, high while data is not ready to move |

## Verification
The checker checks several properties on every cycle. WAIT falls after any cycle with chip enable high. A write never happens while WAIT is high. A rising WAIT is always preceded by a capture strobe or a row crossing. Consecutive write beats step the low two address bits by one. Reads and writes never occur together. Exact latency and stall lengths, the wrap order of each fixed length, the memory-wide wrap, the default row latency, and the data actually stored and returned can only be shown by the bench's scenarios, which write patterns and read them back against a model.

// File: rtl/psb_pkg.sv
package psb_pkg;
  typedef enum logic [1:0] {
    LEN4    = 2'd0,
    LEN8    = 2'd1,
    LEN16   = 2'd2,
    LENCONT = 2'd3
  } blen_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_RUN  = 2'd1,
    ST_DONE = 2'd2
  } bst_e;

  localparam int BEAT_W = 4;  // enough to count the longest fixed burst
endpackage

// File: rtl/psb_addr_step.sv
module psb_addr_step
  import psb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int ROW_W  = 7
) (
  input  logic [ADDR_W-1:0] cur,
  input  blen_e             mode,
  output logic [ADDR_W-1:0] nxt,
  output logic              row_cross
);
  localparam int ROW_HI = ADDR_W - 1;

  always_comb begin
    nxt = cur;
    case (mode)
      LEN4:    nxt[1:0] = cur[1:0] + 2'd1;
      LEN8:    nxt[2:0] = cur[2:0] + 3'd1;
      LEN16:   nxt[3:0] = cur[3:0] + 4'd1;
      default: nxt      = cur + ADDR_W'(1);
    endcase
  end

  // fixed blocks never leave their row, so only linear bursts can cross
  assign row_cross = (mode == LENCONT) && (nxt[ROW_HI:ROW_W] != cur[ROW_HI:ROW_W]);
endmodule

// File: rtl/psb_mem.sv
module psb_mem #(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              we,
  input  logic [ADDR_W-1:0] waddr,
  input  logic [DATA_W-1:0] wdata,
  input  logic              re,
  input  logic [ADDR_W-1:0] raddr,
  output logic [DATA_W-1:0] rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] ram [DEPTH];

  always_ff @(posedge clk) begin
    if (we) ram[waddr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (re) rdata <= ram[raddr];
  end
endmodule

// File: rtl/psb_ctrl.sv
module psb_ctrl
  import psb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [1:0]        cfg_len,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [LAT_W-1:0]  cfg_row_lat,
  input  logic [ADDR_W-1:0] nxt,
  input  logic              row_cross,
  output logic [ADDR_W-1:0] cur_addr,
  output blen_e             mode,
  output logic              wait_o,
  output logic              mem_we,
  output logic              mem_re,
  output logic [ADDR_W-1:0] mem_raddr
);
  bst_e              st_q;
  logic              wr_q;
  logic [LAT_W-1:0]  cnt_q;
  logic [LAT_W-1:0]  rlat_q;
  logic [BEAT_W-1:0] beat_q;
  logic [BEAT_W-1:0] last_idx;
  logic              data_cyc;
  logic              last_beat;
  logic              lat_end;

  always_comb begin
    case (mode)
      LEN4:    last_idx = BEAT_W'(3);
      LEN8:    last_idx = BEAT_W'(7);
      default: last_idx = BEAT_W'(15);
    endcase
  end

  assign data_cyc  = (st_q == ST_RUN) && !wait_o && !ce_n;
  assign last_beat = (mode != LENCONT) && (beat_q == last_idx);
  assign lat_end   = (st_q == ST_RUN) && wait_o && (cnt_q == '0) && !ce_n;

  // read port fetches the word for the data cycle that follows this edge
  assign mem_we    = data_cyc && wr_q;
  assign mem_re    = !wr_q && (lat_end || (data_cyc && !last_beat && !row_cross));
  assign mem_raddr = wait_o ? cur_addr : nxt;

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q     <= ST_IDLE;
      wait_o   <= 1'b0;
      wr_q     <= 1'b0;
      cnt_q    <= '0;
      rlat_q   <= '0;
      beat_q   <= '0;
      cur_addr <= '0;
      mode     <= LEN4;
    end else if (ce_n) begin
      st_q   <= ST_IDLE;
      wait_o <= 1'b0;
    end else begin
      case (st_q)
        ST_IDLE: begin
          if (!adv_n) begin
            cur_addr <= addr;
            wr_q     <= ~we_n;
            mode     <= blen_e'(cfg_len);
            cnt_q    <= cfg_lat - LAT_W'(1);
            rlat_q   <= (cfg_row_lat == '0) ? cfg_lat : cfg_row_lat;
            beat_q   <= '0;
            wait_o   <= 1'b1;
            st_q     <= ST_RUN;
          end
        end
        ST_RUN: begin
          if (wait_o) begin
            if (cnt_q == '0) wait_o <= 1'b0;
            else             cnt_q  <= cnt_q - LAT_W'(1);
          end else begin
            cur_addr <= nxt;
            beat_q   <= beat_q + BEAT_W'(1);
            if (last_beat) begin
              st_q <= ST_DONE;
            end else if (row_cross) begin
              wait_o <= 1'b1;
              cnt_q  <= rlat_q - LAT_W'(1);
            end
          end
        end
        default: ;
      endcase
    end
  end
endmodule

// File: rtl/psram_burst_engine.sv
module psram_burst_engine
  import psb_pkg::*;
#(
  parameter int ADDR_W = 10,
  parameter int DATA_W = 16,
  parameter int ROW_W  = 7,
  parameter int LAT_W  = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              ce_n,
  input  logic              adv_n,
  input  logic              we_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wdata,
  input  logic [1:0]        cfg_len,
  input  logic [LAT_W-1:0]  cfg_lat,
  input  logic [LAT_W-1:0]  cfg_row_lat,
  output logic [DATA_W-1:0] rdata,
  output logic              wait_o
);
  logic [ADDR_W-1:0] cur_addr;
  logic [ADDR_W-1:0] nxt;
  logic [ADDR_W-1:0] mem_raddr;
  logic              row_cross;
  logic              mem_we;
  logic              mem_re;
  blen_e             mode;

  psb_addr_step #(.ADDR_W(ADDR_W), .ROW_W(ROW_W)) u_step (
    .cur       (cur_addr),
    .mode      (mode),
    .nxt       (nxt),
    .row_cross (row_cross)
  );

  psb_ctrl #(.ADDR_W(ADDR_W), .LAT_W(LAT_W)) u_ctrl (
    .clk         (clk),
    .rst         (rst),
    .ce_n        (ce_n),
    .adv_n       (adv_n),
    .we_n        (we_n),
    .addr        (addr),
    .cfg_len     (cfg_len),
    .cfg_lat     (cfg_lat),
    .cfg_row_lat (cfg_row_lat),
    .nxt         (nxt),
    .row_cross   (row_cross),
    .cur_addr    (cur_addr),
    .mode        (mode),
    .wait_o      (wait_o),
    .mem_we      (mem_we),
    .mem_re      (mem_re),
    .mem_raddr   (mem_raddr)
  );

  psb_mem #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_mem (
    .clk   (clk),
    .we    (mem_we),
    .waddr (cur_addr),
    .wdata (wdata),
    .re    (mem_re),
    .raddr (mem_raddr),
    .rdata (rdata)
  );
endmodule

// File: rtl/psb_checker.sv
module psb_checker #(
  parameter int ADDR_W = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              ce_n,
  input logic              adv_n,
  input logic              wait_o,
  input logic              mem_we,
  input logic              mem_re,
  input logic              row_cross,
  input logic [ADDR_W-1:0] cur_addr
);
  assert_ce_high_drops_wait_R10: assert property (@(posedge clk) disable iff (rst)
    ce_n |=> !wait_o);

  assert_no_write_while_wait_R7: assert property (@(posedge clk) disable iff (rst)
    mem_we |-> !wait_o);

  assert_wait_rise_cause_R5: assert property (@(posedge clk) disable iff (rst)
    $rose(wait_o) |-> ($past(!adv_n) || $past(row_cross)));

  assert_beat_addr_step_R3: assert property (@(posedge clk) disable iff (rst)
    (mem_we && $past(mem_we) && !$past(rst)) |-> (cur_addr[1:0] == $past(cur_addr[1:0]) + 2'd1));

  assert_rd_wr_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
    $onehot0({mem_we, mem_re}));
endmodule

bind psram_burst_engine psb_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .ce_n      (ce_n),
  .adv_n     (adv_n),
  .wait_o    (wait_o),
  .mem_we    (mem_we),
  .mem_re    (mem_re),
  .row_cross (row_cross),
  .cur_addr  (cur_addr)
);

// File: tb/psram_burst_engine_tb.sv
module psram_burst_engine_tb;
  localparam int AW = 10;
  localparam int DW = 16;
  localparam int NVEC = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          ce_n = 1'b1;
  logic          adv_n = 1'b1;
  logic          we_n = 1'b1;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wdata = '0;
  logic [1:0]    cfg_len = '0;
  logic [3:0]    cfg_lat = 4'd1;
  logic [3:0]    cfg_row_lat = '0;
  logic [DW-1:0] rdata;
  logic          wait_o;

  int n_chk = 0;
  int n_fail = 0;
  logic [DW-1:0] model [1 << AW];
  logic [DW-1:0] pat = 16'h1000;
  bit done = 1'b0;

  always #5 clk = ~clk;

  psram_burst_engine u_dut (
    .clk(clk), .rst(rst), .ce_n(ce_n), .adv_n(adv_n), .we_n(we_n),
    .addr(addr), .wdata(wdata), .cfg_len(cfg_len), .cfg_lat(cfg_lat),
    .cfg_row_lat(cfg_row_lat), .rdata(rdata), .wait_o(wait_o)
  );

  // {addr, write, len code, latency, row latency, beats}
  localparam logic [26:0] VEC [NVEC] = '{
    {10'h000, 1'b1, 2'd0, 4'd2, 4'd0, 6'd4},
    {10'h000, 1'b0, 2'd0, 4'd3, 4'd0, 6'd4},
    {10'h01A, 1'b1, 2'd1, 4'd1, 4'd0, 6'd8},
    {10'h01C, 1'b0, 2'd1, 4'd2, 4'd0, 6'd8},
    {10'h035, 1'b1, 2'd2, 4'd4, 4'd0, 6'd16},
    {10'h030, 1'b0, 2'd2, 4'd1, 4'd0, 6'd16},
    {10'h07C, 1'b1, 2'd3, 4'd2, 4'd3, 6'd8},
    {10'h07C, 1'b0, 2'd3, 4'd2, 4'd0, 6'd8},
    {10'h3FE, 1'b1, 2'd3, 4'd1, 4'd2, 6'd4},
    {10'h3FE, 1'b0, 2'd3, 4'd3, 4'd1, 6'd4}
  };

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic logic [AW-1:0] step_addr(input logic [AW-1:0] a, input logic [1:0] len);
    logic [AW-1:0] r;
    r = a;
    if (len == 2'd0)      r[1:0] = a[1:0] + 2'd1;
    else if (len == 2'd1) r[2:0] = a[2:0] + 3'd1;
    else if (len == 2'd2) r[3:0] = a[3:0] + 4'd1;
    else                  r = a + 1'b1;
    return r;
  endfunction

  task automatic run_burst(input logic [AW-1:0] a, input bit wr, input logic [1:0] len,
                           input logic [3:0] lat, input logic [3:0] rlat, input int beats);
    logic [AW-1:0] cur;
    logic [AW-1:0] nx;
    int w;
    int effr;
    string dtag;
    string stag;
    effr = (rlat == 0) ? int'(lat) : int'(rlat);
    stag = (rlat == 0) ? "R6" : "R5";
    dtag = (len == 2'd3) ? "R4/R8" : "R3/R8";
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; addr = a; we_n = ~wr;
    cfg_len = len; cfg_lat = lat; cfg_row_lat = rlat;
    @(negedge clk);
    adv_n = 1'b1; addr = ~a; we_n = wr;  // R1: late changes must not matter
    cur = a;
    w = int'(lat);
    for (int b = 0; b < beats; b++) begin
      for (int k = 0; k < w; k++) begin
        wdata = 16'hDEAD;  // R7: never stored during latency or stall
        chk(wait_o === 1'b1, (b == 0) ? "R2" : stag, {31'd0, wait_o}, 32'd1);
        @(negedge clk);
      end
      chk(wait_o === 1'b0, (b == 0) ? "R2" : stag, {31'd0, wait_o}, 32'd0);
      if (wr) begin
        pat = pat + 16'h0101;
        wdata = pat;
        model[cur] = pat;
      end else begin
        chk(rdata === model[cur], dtag, {16'd0, rdata}, {16'd0, model[cur]});
      end
      @(negedge clk);
      nx = step_addr(cur, len);
      w = (len == 2'd3 && nx[AW-1:7] != cur[AW-1:7]) ? effr : 0;
      cur = nx;
    end
    if (len != 2'd3 && beats == (4 << len)) begin
      wdata = 16'hBAD0;  // R9: nothing after the last word
      for (int k = 0; k < 2; k++) begin
        chk(wait_o === 1'b0, "R9", {31'd0, wait_o}, 32'd0);
        @(negedge clk);
      end
    end
    ce_n = 1'b1;
    @(negedge clk);
    chk(wait_o === 1'b0, "R10", {31'd0, wait_o}, 32'd0);
  endtask

  task automatic finish_run;
    if (!done) begin
      done = 1'b1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(wait_o === 1'b0, "R11", {31'd0, wait_o}, 32'd0);

    // R1: strobe high keeps the engine idle
    ce_n = 1'b0; adv_n = 1'b1;
    for (int k = 0; k < 3; k++) begin
      @(negedge clk);
      chk(wait_o === 1'b0, "R1", {31'd0, wait_o}, 32'd0);
    end
    ce_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NVEC; i++) begin
      run_burst(VEC[i][26:17], VEC[i][16], VEC[i][15:14], VEC[i][13:10], VEC[i][9:6], int'(VEC[i][5:0]));
    end

    // R10: write aborted after 5 of 16 words keeps the old tail
    run_burst(10'h100, 1'b1, 2'd2, 4'd2, 4'd0, 16);
    run_burst(10'h100, 1'b1, 2'd2, 4'd2, 4'd0, 5);
    run_burst(10'h100, 1'b0, 2'd2, 4'd1, 4'd0, 16);

    // R7: stall-cycle data ignored across a row edge, checked by read-back
    run_burst(10'h17E, 1'b1, 2'd3, 4'd1, 4'd4, 4);
    run_burst(10'h17E, 1'b0, 2'd3, 4'd2, 4'd2, 4);

    // R11: reset in mid-burst returns to idle
    @(negedge clk);
    ce_n = 1'b0; adv_n = 1'b0; we_n = 1'b1; cfg_lat = 4'd5;
    @(negedge clk);
    adv_n = 1'b1;
    chk(wait_o === 1'b1, "R2", {31'd0, wait_o}, 32'd1);
    rst = 1'b1;
    @(negedge clk);
    chk(wait_o === 1'b0, "R11", {31'd0, wait_o}, 32'd0);
    rst = 1'b0; ce_n = 1'b1;
    @(negedge clk);

    finish_run();
  end

  initial begin
    #2000000;
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end
endmodule